// File: doc/BRIEF.md
# Serial Real-Time Clock Slave

This block is a small clock-calendar device that a host reaches over a two-wire serial link: a serial clock line and a data line, plus a select that frames each transaction. While select is high, every falling edge of the serial clock advances a bit counter. The first eight bits carry a command and the next eight carry a data byte. Depending on the command, the device either returns a byte (scratch RAM, status, control or one of the calendar fields) or takes the received byte into scratch RAM or into the control register.

The calendar runs from a one-pulse-per-second tick and keeps seconds, minutes, hours, day, month and two-digit year in binary. It presents each field as packed BCD when read. An event input sets two status flags and raises an interrupt line. A control write with a particular bit set clears both.

The data line is split into an input, an output and an output enable. The pad is left to the surrounding chip. Everything is sampled in the system clock domain, and the serial clock is edge-detected there.

Top module: `serial_rtc`

## Requirements
- R1: After reset, `irq` and `sdo_oe` are 0, the status byte reads 0x90, the control byte reads 0x00 and every scratch RAM byte reads 0x00.
- R2: The bit counter and the shift registers change only on a falling edge of `sck` seen while `sel` is high. The first eight such edges shift in the command, MSB first.
- R3: For commands 0x00 to 0x1F, the eight data phases return the RAM byte at the address equal to the command, MSB first. `sdo` holds each bit from the falling edge that opens its phase until the falling edge that closes it.
- R4: For commands 0x80 to 0x9F, the data byte (MSB first) is stored into RAM address command minus 0x80, only once the eighth data bit has arrived.
- R5: Command 0x30 returns the status byte and command 0x31 returns the control byte.
- R6: Commands 0x20 to 0x25 return seconds, minutes, hours, day of month, month and year, in that order, each in packed BCD (tens in bits 7:4, units in bits 3:0). Commands 0x26 to 0x2F return 0x00.
- R7: Command 0xB1 stores the data byte into control. If data bit 2 (value 0x04) is set, status bits 4 and 3 (mask 0x18) are cleared and `irq` drops; with bit 2 clear, status and `irq` are unchanged.
- R8: A one-cycle `alarm_evt` pulse sets status bits 0x18 and raises `irq`. If it coincides with a clearing control write, the event wins.
- R9: Dropping `sel` returns the bit counter to zero and abandons a partial transaction. A write cut short stores nothing.
- R10: Each `tick` pulse advances the calendar by one second, with rollover of seconds at 60, minutes at 60 and hours at 24. The day rolls over past the month length, the month past 12, and the year past 99 back to 00.
- R11: February has 29 days when the year is a multiple of four, otherwise 28. April, June, September and November have 30 days, and the other months have 31.
- R12: `sdo_oe` is high only while `sel` is high, during the data phases of a command whose bit 7 is clear. Write commands never drive the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Transaction enable from the host |
| sck | input | 1 | Serial clock from the host, synchronous to clk |
| sdi | input | 1 | Serial data from the host |
| tick | input | 1 | One pulse per second, one clk wide |
| alarm_evt | input | 1 | Event pulse that sets the status flags and the interrupt |
| sdo | output | 1 | Serial data toward the host |
| sdo_oe | output | 1 | Output enable for the data pad |
| irq | output | 1 | Interrupt request, level |

## Verification
A bit counter that is off by one shifts every returned byte by one position. The error shows on `sdo` in the very first read after it occurs, and a write with the same error lands at the wrong RAM address, which the next read-back of that address exposes. A wrong rollover in the calendar stays hidden until a boundary is crossed, so the calendar is started just before the year end and before a leap day. The fields are read right after the crossing. Mistakes in the status or interrupt path show on `irq` one cycle after the event or control write, and in the status byte on the next read.

// File: rtl/serial_rtc_pkg.sv
package serial_rtc_pkg;

  localparam int BYTE_W = 8;

  // binary 0..99 to packed BCD
  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    int i;
    i = int'(v);
    return 8'(((i / 10) << 4) | (i % 10));
  endfunction

  function automatic logic is_leap(input logic [6:0] yr);
    return (yr[1:0] == 2'b00);
  endfunction

  // number of days in a month (1..12) for a two-digit year
  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                       return is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import serial_rtc_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 sck,
  input  logic                 sdi,
  input  logic [BW-1:0]        load_val,
  output logic                 fall_evt,
  output logic [$clog2(2*BW+1)-1:0] phase,
  output logic [BW-1:0]        cmd_q,
  output logic [BW-1:0]        cmd_next,
  output logic [BW-1:0]        data_next,
  output logic                 cmd_done,
  output logic                 data_done,
  output logic                 in_data,
  output logic                 sdo
);
  localparam int PW = $clog2(2*BW+1);
  localparam logic [PW-1:0] PH_CMD  = PW'(BW);
  localparam logic [PW-1:0] PH_END  = PW'(2*BW);

  logic          sck_q;
  logic [BW-1:0] data_q;
  logic [BW-1:0] out_sr;
  logic          in_cmd;

  assign fall_evt  = sel & sck_q & ~sck;
  assign in_cmd    = (phase < PH_CMD);
  assign in_data   = (phase >= PH_CMD) && (phase < PH_END);
  assign cmd_next  = {cmd_q[BW-2:0], sdi};
  assign data_next = {data_q[BW-2:0], sdi};
  assign cmd_done  = fall_evt && (phase == PH_CMD - 1'b1);
  assign data_done = fall_evt && (phase == PH_END - 1'b1);
  assign sdo       = out_sr[BW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      phase  <= '0;
      cmd_q  <= '0;
      data_q <= '0;
      out_sr <= '0;
    end else begin
      sck_q <= sck;
      if (!sel) begin
        phase <= '0;
      end else if (fall_evt) begin
        if (phase != PH_END) phase <= phase + 1'b1;
        if (in_cmd)  cmd_q  <= cmd_next;
        if (in_data) data_q <= data_next;
        if (cmd_done)     out_sr <= load_val;
        else if (in_data) out_sr <= {out_sr[BW-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import serial_rtc_pkg::*;
#(
  parameter int INIT_SEC  = 0,
  parameter int INIT_MIN  = 0,
  parameter int INIT_HOUR = 0,
  parameter int INIT_DAY  = 1,
  parameter int INIT_MON  = 1,
  parameter int INIT_YEAR = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  output logic [5:0] sec,
  output logic [5:0] mins,
  output logic [4:0] hour,
  output logic [4:0] day,
  output logic [3:0] mon,
  output logic [6:0] year
);
  logic [4:0] mlen;
  assign mlen = month_len(mon, year);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec  <= 6'(INIT_SEC);
      mins <= 6'(INIT_MIN);
      hour <= 5'(INIT_HOUR);
      day  <= 5'(INIT_DAY);
      mon  <= 4'(INIT_MON);
      year <= 7'(INIT_YEAR);
    end else if (tick) begin
      if (sec != 6'd59) begin
        sec <= sec + 1'b1;
      end else begin
        sec <= '0;
        if (mins != 6'd59) begin
          mins <= mins + 1'b1;
        end else begin
          mins <= '0;
          if (hour != 5'd23) begin
            hour <= hour + 1'b1;
          end else begin
            hour <= '0;
            if (day != mlen) begin
              day <= day + 1'b1;
            end else begin
              day <= 5'd1;
              if (mon != 4'd12) begin
                mon <= mon + 1'b1;
              end else begin
                mon  <= 4'd1;
                year <= (year == 7'd99) ? 7'd0 : year + 1'b1;
              end
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/serial_rtc.sv
module serial_rtc
  import serial_rtc_pkg::*;
#(
  parameter int          RAM_WORDS  = 32,
  parameter logic [7:0]  STATUS_RST = 8'h90,
  parameter int          INIT_SEC   = 0,
  parameter int          INIT_MIN   = 0,
  parameter int          INIT_HOUR  = 0,
  parameter int          INIT_DAY   = 1,
  parameter int          INIT_MON   = 1,
  parameter int          INIT_YEAR  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck,
  input  logic sdi,
  input  logic tick,
  input  logic alarm_evt,
  output logic sdo,
  output logic sdo_oe,
  output logic irq
);
  localparam int          AW        = $clog2(RAM_WORDS);
  localparam int          PW        = $clog2(2*BYTE_W+1);
  localparam logic [7:0]  WR_BASE   = 8'h80;
  localparam logic [7:0]  CMD_TIME  = 8'h20;
  localparam logic [7:0]  CMD_STAT  = 8'h30;
  localparam logic [7:0]  CMD_CTRL  = 8'h31;
  localparam logic [7:0]  CMD_CTLWR = 8'hB1;
  localparam logic [7:0]  FLAG_MASK = 8'h18;
  localparam int          CLR_BIT   = 2;

  // named internal events
  logic          fall_evt, cmd_done, data_done, in_data;
  logic [PW-1:0] phase;
  logic [7:0]    cmd_q, cmd_next, data_next, load_val;
  logic          ram_wr, ctrl_wr, ctrl_clr;

  logic [7:0] ram [RAM_WORDS];
  logic [7:0] status_q, ctrl_q;

  logic [5:0] sec_bin, min_bin;
  logic [4:0] hour_bin, day_bin;
  logic [3:0] mon_bin;
  logic [6:0] year_bin;

  rtc_serial_port #(.BW(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi),
    .load_val(load_val), .fall_evt(fall_evt), .phase(phase),
    .cmd_q(cmd_q), .cmd_next(cmd_next), .data_next(data_next),
    .cmd_done(cmd_done), .data_done(data_done), .in_data(in_data), .sdo(sdo)
  );

  rtc_timekeeper #(
    .INIT_SEC(INIT_SEC), .INIT_MIN(INIT_MIN), .INIT_HOUR(INIT_HOUR),
    .INIT_DAY(INIT_DAY), .INIT_MON(INIT_MON), .INIT_YEAR(INIT_YEAR)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sec(sec_bin), .mins(min_bin), .hour(hour_bin),
    .day(day_bin), .mon(mon_bin), .year(year_bin)
  );

  // read value chosen from the command as it completes
  always_comb begin
    load_val = 8'h00;
    if (cmd_next[7:AW] == '0) begin
      load_val = ram[cmd_next[AW-1:0]];
    end else begin
      case (cmd_next)
        CMD_TIME + 8'd0: load_val = bin2bcd(7'(sec_bin));
        CMD_TIME + 8'd1: load_val = bin2bcd(7'(min_bin));
        CMD_TIME + 8'd2: load_val = bin2bcd(7'(hour_bin));
        CMD_TIME + 8'd3: load_val = bin2bcd(7'(day_bin));
        CMD_TIME + 8'd4: load_val = bin2bcd(7'(mon_bin));
        CMD_TIME + 8'd5: load_val = bin2bcd(year_bin);
        CMD_STAT:        load_val = status_q;
        CMD_CTRL:        load_val = ctrl_q;
        default:         load_val = 8'h00;
      endcase
    end
  end

  assign ram_wr   = data_done && (cmd_q[7:AW] == WR_BASE[7:AW]);
  assign ctrl_wr  = data_done && (cmd_q == CMD_CTLWR);
  assign ctrl_clr = ctrl_wr && data_next[CLR_BIT];
  assign sdo_oe   = sel && in_data && !cmd_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_WORDS; i++) ram[i] <= 8'h00;
    end else if (ram_wr) begin
      ram[cmd_q[AW-1:0]] <= data_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      ctrl_q   <= 8'h00;
      irq      <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= data_next;
      if (alarm_evt) begin
        status_q <= status_q | FLAG_MASK;
        irq      <= 1'b1;
      end else if (ctrl_clr) begin
        status_q <= status_q & ~FLAG_MASK;
        irq      <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_rtc_chk.sv
module serial_rtc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel,
  input logic       fall_evt,
  input logic [4:0] phase,
  input logic       sdo_oe,
  input logic       ctrl_clr,
  input logic       alarm_evt,
  input logic       irq,
  input logic       tick,
  input logic [5:0] sec
);
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !fall_evt) |=> $stable(phase));
  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (phase == 5'd0));
  // R12
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (sel && phase >= 5'd8 && phase < 5'd16));
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clr && !alarm_evt) |=> !irq);
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> irq);
  // R10
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec == 6'd59) |=> (sec == 6'd0));
  // R10
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec < 6'd60);
endmodule

bind serial_rtc serial_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .fall_evt(fall_evt), .phase(phase),
  .sdo_oe(sdo_oe), .ctrl_clr(ctrl_clr), .alarm_evt(alarm_evt), .irq(irq),
  .tick(tick), .sec(sec_bin)
);

// File: tb/serial_rtc_bench.sv
module serial_rtc_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic tick_a = 1'b0, tick_b = 1'b0, alarm_a = 1'b0;
  logic sdo_a, oe_a, irq_a, sdo_b, oe_b, irq_b;

  int checks = 0;
  int failures = 0;
  int oe_bad = 0;
  int cycles = 0;
  logic in_wr = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  serial_rtc #(.INIT_SEC(58), .INIT_MIN(59), .INIT_HOUR(23),
               .INIT_DAY(31), .INIT_MON(12), .INIT_YEAR(99)) u_serial_rtc (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi), .tick(tick_a),
    .alarm_evt(alarm_a), .sdo(sdo_a), .sdo_oe(oe_a), .irq(irq_a));

  serial_rtc #(.INIT_SEC(59), .INIT_MIN(59), .INIT_HOUR(23),
               .INIT_DAY(28), .INIT_MON(2), .INIT_YEAR(24)) u_serial_rtc_b (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck(sck), .sdi(sdi), .tick(tick_b),
    .alarm_evt(1'b0), .sdo(sdo_b), .sdo_oe(oe_b), .irq(irq_b));

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic logic [7:0] pattern(input int a);
    return 8'((a * 37 + 5) ^ 8'h5A);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // nbits edges in total; sel drops afterwards
  task automatic xfer(input logic [7:0] c, input logic [7:0] d, input int nbits,
                      output logic [7:0] ra, output logic [7:0] rb);
    ra = '0; rb = '0;
    in_wr = c[7];
    @(negedge clk) sel = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      sdi = (i < 8) ? c[7-i] : d[15-i];
      sck = 1'b1;
      @(negedge clk); @(negedge clk);
      if (i >= 8) begin
        ra = {ra[6:0], sdo_a};
        rb = {rb[6:0], sdo_b};
      end
      sck = 1'b0;
      @(negedge clk); @(negedge clk);
    end
    sel = 1'b0;
    in_wr = 1'b0;
    @(negedge clk);
  endtask

  always @(negedge clk) if (in_wr && (oe_a || oe_b)) oe_bad++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary();
    end
  end

  initial begin
    logic [7:0] ra, rb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {7'b0, oe_a}, 8'h00);
    chk("R1 irq", {7'b0, irq_a}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(8'h30, 8'h00, 16, ra, rb); chk("R1 R5 status", ra, 8'h90);
    xfer(8'h31, 8'h00, 16, ra, rb); chk("R1 R5 control", ra, 8'h00);
    xfer(8'h07, 8'h00, 16, ra, rb); chk("R1 ram", ra, 8'h00);

    // R3 R4 full RAM sweep
    for (int a = 0; a < 32; a++) xfer(8'(8'h80 + a), pattern(a), 16, ra, rb);
    for (int a = 0; a < 32; a++) begin
      xfer(8'(a), 8'hFF, 16, ra, rb);
      chk($sformatf("R3 R4 ram[%0d]", a), ra, pattern(a));
    end
    chk("R12 write never drives", 8'(oe_bad), 8'h00);

    // R9 aborted write after 4 data bits and mid-command
    xfer(8'h85, 8'hC3, 12, ra, rb);
    xfer(8'h85, 8'h3C, 5, ra, rb);
    xfer(8'h05, 8'h00, 16, ra, rb); chk("R9 abort keeps ram", ra, pattern(5));
    // R2 counter back at zero after abort: next full read is aligned
    xfer(8'h1F, 8'h00, 16, ra, rb); chk("R2 R9 aligned", ra, pattern(31));

    // R6 calendar fields
    xfer(8'h20, 8'h00, 16, ra, rb); chk("R6 sec", ra, bcd(58));
    xfer(8'h21, 8'h00, 16, ra, rb); chk("R6 min", ra, bcd(59));
    xfer(8'h22, 8'h00, 16, ra, rb); chk("R6 hour", ra, bcd(23));
    xfer(8'h23, 8'h00, 16, ra, rb); chk("R6 day", ra, bcd(31));
    xfer(8'h24, 8'h00, 16, ra, rb); chk("R6 mon", ra, bcd(12));
    xfer(8'h25, 8'h00, 16, ra, rb); chk("R6 year", ra, bcd(99));
    xfer(8'h26, 8'h00, 16, ra, rb); chk("R6 unused", ra, 8'h00);

    // R10 year-end rollover
    repeat (2) begin
      @(negedge clk) tick_a = 1'b1;
      @(negedge clk) tick_a = 1'b0;
    end
    xfer(8'h20, 8'h00, 16, ra, rb); chk("R10 sec", ra, 8'h00);
    xfer(8'h22, 8'h00, 16, ra, rb); chk("R10 hour", ra, 8'h00);
    xfer(8'h23, 8'h00, 16, ra, rb); chk("R10 day", ra, bcd(1));
    xfer(8'h24, 8'h00, 16, ra, rb); chk("R10 mon", ra, bcd(1));
    xfer(8'h25, 8'h00, 16, ra, rb); chk("R10 year", ra, bcd(0));

    // R11 leap day then March
    @(negedge clk) tick_b = 1'b1;
    @(negedge clk) tick_b = 1'b0;
    xfer(8'h23, 8'h00, 16, ra, rb); chk("R11 leap day", rb, bcd(29));
    xfer(8'h24, 8'h00, 16, ra, rb); chk("R11 leap mon", rb, bcd(2));
    @(negedge clk) tick_b = 1'b1;
    repeat (86400) @(negedge clk);
    tick_b = 1'b0;
    xfer(8'h23, 8'h00, 16, ra, rb); chk("R11 R10 day", rb, bcd(1));
    xfer(8'h24, 8'h00, 16, ra, rb); chk("R11 R10 mon", rb, bcd(3));
    xfer(8'h25, 8'h00, 16, ra, rb); chk("R11 year", rb, bcd(24));

    // R8 event
    @(negedge clk) alarm_a = 1'b1;
    @(negedge clk) alarm_a = 1'b0;
    chk("R8 irq", {7'b0, irq_a}, 8'h01);
    xfer(8'h30, 8'h00, 16, ra, rb); chk("R8 status", ra, 8'h98);
    // R7 control write without clear bit
    xfer(8'hB1, 8'hA3, 16, ra, rb);
    chk("R7 irq kept", {7'b0, irq_a}, 8'h01);
    xfer(8'h31, 8'h00, 16, ra, rb); chk("R7 R5 control", ra, 8'hA3);
    xfer(8'h30, 8'h00, 16, ra, rb); chk("R7 status kept", ra, 8'h98);
    // R7 with clear bit
    xfer(8'hB1, 8'h04, 16, ra, rb);
    chk("R7 irq cleared", {7'b0, irq_a}, 8'h00);
    xfer(8'h30, 8'h00, 16, ra, rb); chk("R7 status cleared", ra, 8'h80);
    xfer(8'h31, 8'h00, 16, ra, rb); chk("R7 control", ra, 8'h04);
    chk("R12 final write drive count", 8'(oe_bad), 8'h00);
    chk("R12 idle oe", {7'b0, oe_a | oe_b}, 8'h00);

    done = 1'b1;
    summary();
  end
endmodule